// File: doc/BRIEF.md
# Shared-Ramp Two-Phase Comparator Offset Calibration Controller

This controller trims the input offset of every comparator in an array using two ramps that all lanes share. A central sequencer runs a coarse ramp on a narrow counter, then a fine ramp on a wider one, and drives both codes to every lane at once. Each lane carries only a few flops. When calibration starts, a lane records its comparator's resting polarity. That polarity selects the compensation side for the lane. The lane then freezes a copy of the shared code on the first cycle its comparator disagrees with the reference polarity of the current phase.

The coarse ramp moves in large steps, so a lane's output normally reverses partway up it. The fine ramp then moves in small steps and brings the output back across the threshold. The digital-to-analog converters, the current compensation and the delay tuning are outside the block. Here they appear only as code outputs: the shared codes, the per-lane held codes and the per-lane side select. A lane that never reverses within a phase takes the saturated code and raises its out-of-range flag. The design targets a 50 MHz clock.

Top module: `ofs_cal_ctrl`

## Requirements
- R1: After reset, phase_o is 0 (idle), done_o is 0, and both shared codes, side_o, all held lane codes and oor_o are zero.
- R2: A high start_i is accepted only in idle (phase 0) or done (phase 3). Acceptance has four effects: phase_o becomes 1 (coarse), both shared codes become 0, every held code and oor_o bit clears, and each lane's side_o bit takes that lane's cmp_i value. A start_i during coarse (1) or fine (2) has no effect.
- R3: In coarse, coarse_code_o starts at 0 and rises by one per cycle until the phase ends, never passing 2^CW-1. Outside coarse it keeps its value until the next accepted start.
- R4: In coarse, lane i captures the current coarse_code_o into lane_coarse_o[i*CW +: CW] on the first cycle that cmp_i[i] differs from side_o[i]. Later cmp_i changes leave that field unchanged until the next start.
- R5: Coarse ends after the first cycle in which every lane has captured, counting lanes that capture in that same cycle, or after the cycle in which coarse_code_o is 2^CW-1. At that point each lane that has not captured holds 2^CW-1 and sets its oor_o bit.
- R6: When coarse ends, phase_o becomes 2 (fine). Each lane records its cmp_i value of that last coarse cycle as its fine reference. fine_code_o starts at 0 and rises by one per fine cycle, never passing 2^FW-1. Outside fine it keeps its value until the next accepted start.
- R7: In fine, lane i captures the current fine_code_o into lane_fine_o[i*FW +: FW] on the first cycle that cmp_i[i] differs from its fine reference. Later changes are ignored until the next start.
- R8: Fine ends after the first cycle in which every lane has a fine capture, or after the cycle in which fine_code_o is 2^FW-1. Lanes without a fine capture then hold 2^FW-1 and set oor_o. phase_o then becomes 3 and done_o is 1, and both shared codes hold.
- R9: side_o changes only on an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Calibration start request |
| cmp_i | input | LANES | Comparator decision, one bit per lane |
| coarse_code_o | output | CW | Shared coarse ramp code |
| fine_code_o | output | FW | Shared fine ramp code |
| side_o | output | LANES | Per-lane compensation side (1 = positive side) |
| lane_coarse_o | output | LANES*CW | Per-lane held coarse code, lane i at bits i*CW +: CW |
| lane_fine_o | output | LANES*FW | Per-lane held fine code, lane i at bits i*FW +: FW |
| oor_o | output | LANES | Per-lane out-of-range flag |
| phase_o | output | 2 | 0 idle, 1 coarse, 2 fine, 3 done |
| done_o | output | 1 | Calibration complete |

## Verification
The assertions assume that cmp_i is already synchronous to clk. They also assume that start_i is a level sampled on each edge, so a start held high in done restarts every cycle. The bench drives cmp_i and start_i only at the falling edge, and the values it drives come either from a behavioural comparator whose output depends on the codes applied to it, or from a pseudo-random pattern. Start pulses reach the block in idle, in done, and in the middle of both ramps. The stimulus includes lanes that reverse on the first coarse step, a lane whose offset lies beyond full coarse range, and an array whose lanes all latch early, so that the coarse phase ends before the counter saturates.

// File: rtl/ofs_cal_pkg.sv
package ofs_cal_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_COARSE = 2'd1,
    PH_FINE   = 2'd2,
    PH_DONE   = 2'd3
  } phase_e;
endpackage

// File: rtl/ofs_cal_seq.sv
module ofs_cal_seq
  import ofs_cal_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CW    = 6,
  parameter int FW    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LANES-1:0] c_ok_i,
  input  logic [LANES-1:0] f_ok_i,
  output logic             go_o,
  output logic             in_coarse_o,
  output logic             in_fine_o,
  output logic             c_end_o,
  output logic             f_end_o,
  output logic [CW-1:0]    ccode_o,
  output logic [FW-1:0]    fcode_o,
  output phase_e           phase_o
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam logic [FW-1:0] FMAX = {FW{1'b1}};

  phase_e        st_q, st_d;
  logic [CW-1:0] cc_q, cc_d;
  logic [FW-1:0] fc_q, fc_d;
  logic          cc_en, fc_en;

  assign go_o        = start_i & ((st_q == PH_IDLE) | (st_q == PH_DONE));
  assign in_coarse_o = (st_q == PH_COARSE);
  assign in_fine_o   = (st_q == PH_FINE);
  assign c_end_o     = in_coarse_o & ((&c_ok_i) | (cc_q == CMAX));
  assign f_end_o     = in_fine_o & ((&f_ok_i) | (fc_q == FMAX));

  always_comb begin
    st_d  = st_q;
    cc_d  = cc_q;
    fc_d  = fc_q;
    cc_en = 1'b0;
    fc_en = 1'b0;
    if (go_o) begin
      st_d  = PH_COARSE;
      cc_d  = '0;
      fc_d  = '0;
      cc_en = 1'b1;
      fc_en = 1'b1;
    end else begin
      case (st_q)
        PH_COARSE: begin
          if (c_end_o) st_d = PH_FINE;
          else begin
            cc_d  = cc_q + 1'b1;
            cc_en = 1'b1;
          end
        end
        PH_FINE: begin
          if (f_end_o) st_d = PH_DONE;
          else begin
            fc_d  = fc_q + 1'b1;
            fc_en = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PH_IDLE;
      cc_q <= '0;
      fc_q <= '0;
    end else begin
      st_q <= st_d;
      if (cc_en) cc_q <= cc_d;
      if (fc_en) fc_q <= fc_d;
    end
  end

  assign ccode_o = cc_q;
  assign fcode_o = fc_q;
  assign phase_o = st_q;

  // R3: coarse code frozen outside the coarse ramp
  a_r3_coarse_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != PH_COARSE && !go_o) |=> $stable(cc_q));
  // R6: fine code frozen outside the fine ramp
  a_r6_fine_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != PH_FINE && !go_o) |=> $stable(fc_q));
  // R5: saturated coarse counter forces the fine phase
  a_r5_coarse_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_COARSE && cc_q == CMAX) |=> (st_q == PH_FINE));
  // R8: saturated fine counter forces done
  a_r8_fine_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_FINE && fc_q == FMAX) |=> (st_q == PH_DONE));
  // R2: start during the fine ramp does not restart it
  a_r2_fine_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_FINE && start_i) |=> (st_q != PH_COARSE));
endmodule

// File: rtl/ofs_cal_lane.sv
module ofs_cal_lane #(
  parameter int CW = 6,
  parameter int FW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic          in_coarse_i,
  input  logic          in_fine_i,
  input  logic          c_end_i,
  input  logic          f_end_i,
  input  logic          cmp_i,
  input  logic [CW-1:0] ccode_i,
  input  logic [FW-1:0] fcode_i,
  output logic          c_ok_o,
  output logic          f_ok_o,
  output logic          side_o,
  output logic          oor_o,
  output logic [CW-1:0] c_hold_o,
  output logic [FW-1:0] f_hold_o
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam logic [FW-1:0] FMAX = {FW{1'b1}};

  logic          side_q, side_d, ref_q, ref_d;
  logic          c_lat_q, c_lat_d, f_lat_q, f_lat_d, oor_q, oor_d;
  logic [CW-1:0] c_hold_q, c_hold_d;
  logic [FW-1:0] f_hold_q, f_hold_d;
  logic          flip, c_hit, f_hit;

  assign flip   = cmp_i ^ ref_q;
  assign c_hit  = in_coarse_i & ~c_lat_q & flip;
  assign f_hit  = in_fine_i & ~f_lat_q & flip;
  assign c_ok_o = c_lat_q | c_hit;
  assign f_ok_o = f_lat_q | f_hit;

  always_comb begin
    side_d   = side_q;
    ref_d    = ref_q;
    c_lat_d  = c_lat_q;
    f_lat_d  = f_lat_q;
    oor_d    = oor_q;
    c_hold_d = c_hold_q;
    f_hold_d = f_hold_q;
    if (go_i) begin
      side_d   = cmp_i;
      ref_d    = cmp_i;
      c_lat_d  = 1'b0;
      f_lat_d  = 1'b0;
      oor_d    = 1'b0;
      c_hold_d = '0;
      f_hold_d = '0;
    end else begin
      if (c_hit || (c_end_i && !c_ok_o)) begin
        c_lat_d  = 1'b1;
        c_hold_d = ccode_i;
      end
      if (c_end_i) begin
        ref_d = cmp_i;
        if (!c_ok_o) oor_d = 1'b1;
      end
      if (f_hit || (f_end_i && !f_ok_o)) begin
        f_lat_d  = 1'b1;
        f_hold_d = fcode_i;
      end
      if (f_end_i && !f_ok_o) oor_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      side_q   <= 1'b0;
      ref_q    <= 1'b0;
      c_lat_q  <= 1'b0;
      f_lat_q  <= 1'b0;
      oor_q    <= 1'b0;
      c_hold_q <= '0;
      f_hold_q <= '0;
    end else begin
      side_q   <= side_d;
      ref_q    <= ref_d;
      c_lat_q  <= c_lat_d;
      f_lat_q  <= f_lat_d;
      oor_q    <= oor_d;
      c_hold_q <= c_hold_d;
      f_hold_q <= f_hold_d;
    end
  end

  assign side_o   = side_q;
  assign oor_o    = oor_q;
  assign c_hold_o = c_hold_q;
  assign f_hold_o = f_hold_q;

  // R9: side select only moves on an accepted start
  a_r9_side_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    !go_i |=> $stable(side_q));
  // R4: a captured coarse code is frozen
  a_r4_coarse_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (c_lat_q && !go_i) |=> $stable(c_hold_q));
  // R7: a captured fine code is frozen
  a_r7_fine_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (f_lat_q && !go_i) |=> $stable(f_hold_q));
  // R5: out-of-range only ever comes with a saturated held code
  a_r5_oor_saturated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oor_q) |-> (c_hold_q == CMAX || f_hold_q == FMAX));
endmodule

// File: rtl/ofs_cal_ctrl.sv
module ofs_cal_ctrl
  import ofs_cal_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CW    = 6,
  parameter int FW    = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [LANES-1:0]    cmp_i,
  output logic [CW-1:0]       coarse_code_o,
  output logic [FW-1:0]       fine_code_o,
  output logic [LANES-1:0]    side_o,
  output logic [LANES*CW-1:0] lane_coarse_o,
  output logic [LANES*FW-1:0] lane_fine_o,
  output logic [LANES-1:0]    oor_o,
  output logic [1:0]          phase_o,
  output logic                done_o
);
  logic [1:0]       rsync_q;
  logic             rst_core_n;
  logic             go, in_coarse, in_fine, c_end, f_end;
  logic [LANES-1:0] c_ok, f_ok;
  logic [CW-1:0]    ccode;
  logic [FW-1:0]    fcode;
  phase_e           phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  ofs_cal_seq #(.LANES(LANES), .CW(CW), .FW(FW)) seq_i (
    .clk(clk), .rst_n(rst_core_n), .start_i(start_i),
    .c_ok_i(c_ok), .f_ok_i(f_ok), .go_o(go),
    .in_coarse_o(in_coarse), .in_fine_o(in_fine),
    .c_end_o(c_end), .f_end_o(f_end),
    .ccode_o(ccode), .fcode_o(fcode), .phase_o(phase)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ofs_cal_lane #(.CW(CW), .FW(FW)) lane_i (
      .clk(clk), .rst_n(rst_core_n), .go_i(go),
      .in_coarse_i(in_coarse), .in_fine_i(in_fine),
      .c_end_i(c_end), .f_end_i(f_end), .cmp_i(cmp_i[g]),
      .ccode_i(ccode), .fcode_i(fcode),
      .c_ok_o(c_ok[g]), .f_ok_o(f_ok[g]),
      .side_o(side_o[g]), .oor_o(oor_o[g]),
      .c_hold_o(lane_coarse_o[g*CW +: CW]),
      .f_hold_o(lane_fine_o[g*FW +: FW])
    );
  end

  assign coarse_code_o = ccode;
  assign fine_code_o   = fcode;
  assign phase_o       = phase;
  assign done_o        = (phase == PH_DONE);

  // R8: done flag stays up until a start restarts calibration
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_core_n)
    (done_o && !start_i) |=> (done_o && $stable(fine_code_o)));
endmodule

// File: tb/ofs_cal_ctrl_tb_top.sv
`timescale 1ns/1ps
module ofs_cal_ctrl_tb_top;
  localparam int L  = 4;
  localparam int CW = 6;
  localparam int FW = 10;
  localparam int CMAX = (1 << CW) - 1;
  localparam int FMAX = (1 << FW) - 1;
  localparam int CSTEP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [L-1:0] cmp_i = '0;
  logic [CW-1:0] coarse_code_o;
  logic [FW-1:0] fine_code_o;
  logic [L-1:0] side_o, oor_o;
  logic [L*CW-1:0] lane_coarse_o;
  logic [L*FW-1:0] lane_fine_o;
  logic [1:0] phase_o;
  logic done_o;

  ofs_cal_ctrl #(.LANES(L), .CW(CW), .FW(FW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
    .coarse_code_o(coarse_code_o), .fine_code_o(fine_code_o),
    .side_o(side_o), .lane_coarse_o(lane_coarse_o), .lane_fine_o(lane_fine_o),
    .oor_o(oor_o), .phase_o(phase_o), .done_o(done_o)
  );

  always #10 clk = ~clk;

  // reference model state
  int mst, mc, mf;
  int mside[L], mref[L], mcl[L], mfl[L], moor[L], mch[L], mfh[L];
  int ofs[L];
  int mode;
  logic [15:0] lfsr = 16'hACE1;
  int vectors = 0;
  int fails = 0;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [L*CW-1:0] ec;
    logic [L*FW-1:0] ef;
    logic [L-1:0] es, eo;
    for (int i = 0; i < L; i++) begin
      ec[i*CW +: CW] = mch[i][CW-1:0];
      ef[i*FW +: FW] = mfh[i][FW-1:0];
      es[i] = mside[i][0];
      eo[i] = moor[i][0];
    end
    chk("R8", "phase", 64'(phase_o), 64'(mst));
    chk("R8", "done", 64'(done_o), 64'(mst == 3));
    chk("R3", "coarse code", 64'(coarse_code_o), 64'(mc));
    chk("R6", "fine code", 64'(fine_code_o), 64'(mf));
    chk("R9", "side", 64'(side_o), 64'(es));
    chk("R4", "lane coarse", 64'(lane_coarse_o), 64'(ec));
    chk("R7", "lane fine", 64'(lane_fine_o), 64'(ef));
    chk("R5", "oor", 64'(oor_o), 64'(eo));
  endtask

  // behavioural comparator with offset and applied compensation
  function automatic bit comp_model(int i, bit raw);
    int s, ca, fa, eff;
    s = (mside[i] != 0) ? 1 : -1;
    ca = 0;
    fa = 0;
    if (!raw) begin
      case (mst)
        1: ca = (mcl[i] != 0) ? mch[i] : mc;
        2: begin ca = mch[i]; fa = (mfl[i] != 0) ? mfh[i] : mf; end
        3: begin ca = mch[i]; fa = mfh[i]; end
        default: ;
      endcase
    end
    eff = ofs[i] - s * ca * CSTEP + s * fa;
    return eff > 0;
  endfunction

  // drive one cycle at a falling edge, advance model, compare at next falling edge
  task automatic step(input bit st, input bit raw);
    int c[L], cok[L], fok[L], chit[L], fhit[L];
    int allc, allf, cend, fend, go;
    for (int i = 0; i < L; i++) begin
      c[i] = (mode != 0) ? int'(lfsr[i*3]) : int'(comp_model(i, raw));
      cmp_i[i] = c[i][0];
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    start_i = st;
    go = st && (mst == 0 || mst == 3);
    allc = 1;
    allf = 1;
    for (int i = 0; i < L; i++) begin
      chit[i] = (mst == 1) && (mcl[i] == 0) && (c[i] != mref[i]);
      fhit[i] = (mst == 2) && (mfl[i] == 0) && (c[i] != mref[i]);
      cok[i] = (mcl[i] != 0) || (chit[i] != 0);
      fok[i] = (mfl[i] != 0) || (fhit[i] != 0);
      if (cok[i] == 0) allc = 0;
      if (fok[i] == 0) allf = 0;
    end
    cend = (mst == 1) && (allc != 0 || mc == CMAX);
    fend = (mst == 2) && (allf != 0 || mf == FMAX);
    if (go) begin
      mst = 1; mc = 0; mf = 0;
      for (int i = 0; i < L; i++) begin
        mside[i] = c[i]; mref[i] = c[i];
        mcl[i] = 0; mfl[i] = 0; moor[i] = 0; mch[i] = 0; mfh[i] = 0;
      end
    end else begin
      for (int i = 0; i < L; i++) begin
        if (chit[i] != 0 || (cend != 0 && cok[i] == 0)) begin mcl[i] = 1; mch[i] = mc; end
        if (cend != 0 && cok[i] == 0) moor[i] = 1;
        if (cend != 0) mref[i] = c[i];
        if (fhit[i] != 0 || (fend != 0 && fok[i] == 0)) begin mfl[i] = 1; mfh[i] = mf; end
        if (fend != 0 && fok[i] == 0) moor[i] = 1;
      end
      if (mst == 1) begin
        if (cend != 0) mst = 2; else mc++;
      end else if (mst == 2) begin
        if (fend != 0) mst = 3; else mf++;
      end
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic run_to_done();
    while (mst != 3) step(1'b0, 1'b0);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog: actual not done expected done");
    summary();
    $finish;
  end

  initial begin
    mst = 0; mc = 0; mf = 0; mode = 0;
    for (int i = 0; i < L; i++) begin
      mside[i] = 0; mref[i] = 0; mcl[i] = 0; mfl[i] = 0;
      moor[i] = 0; mch[i] = 0; mfh[i] = 0; ofs[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "phase after reset", 64'(phase_o), 64'd0);
    chk("R1", "done after reset", 64'(done_o), 64'd0);
    chk("R1", "codes after reset", 64'({coarse_code_o, fine_code_o}), 64'd0);
    chk("R1", "lanes after reset", 64'({side_o, oor_o, lane_coarse_o}), 64'd0);
    chk("R1", "fine holds after reset", 64'(lane_fine_o), 64'd0);
    compare_all();

    // run 1: analog model, lane 2 beyond coarse range
    ofs[0] = 100; ofs[1] = -37; ofs[2] = 2000; ofs[3] = 0;
    step(1'b1, 1'b1);
    chk("R2", "phase after start", 64'(phase_o), 64'd1);
    chk("R2", "side captured", 64'(side_o), 64'b0101);
    chk("R2", "codes zero at start", 64'({coarse_code_o, fine_code_o}), 64'd0);
    run_to_done();
    chk("R4", "coarse holds run1", 64'(lane_coarse_o), 64'({6'd1, 6'd63, 6'd3, 6'd7}));
    chk("R7", "fine holds run1", 64'(lane_fine_o), 64'({10'd16, 10'd1023, 10'd11, 10'd13}));
    chk("R5", "oor run1", 64'(oor_o), 64'b0100);
    chk("R3", "coarse saturated held", 64'(coarse_code_o), 64'(CMAX));
    chk("R8", "fine saturated held", 64'(fine_code_o), 64'(FMAX));
    chk("R8", "done run1", 64'(done_o), 64'd1);
    repeat (3) step(1'b0, 1'b0);

    // run 2: restart from done, all lanes latch early
    ofs[0] = 50; ofs[1] = -50; ofs[2] = 5; ofs[3] = -5;
    step(1'b1, 1'b1);
    chk("R5", "oor cleared by restart", 64'(oor_o), 64'd0);
    while (mst != 2) step(1'b0, 1'b0);
    chk("R5", "early coarse end code", 64'(coarse_code_o), 64'd4);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    chk("R2", "start ignored in fine", 64'(phase_o), 64'd2);
    run_to_done();
    chk("R4", "coarse holds run2", 64'(lane_coarse_o), 64'({6'd1, 6'd1, 6'd4, 6'd4}));
    chk("R7", "fine holds run2", 64'(lane_fine_o), 64'({10'd11, 10'd12, 10'd14, 10'd15}));
    chk("R6", "fine end code run2", 64'(fine_code_o), 64'd15);
    chk("R5", "no oor run2", 64'(oor_o), 64'd0);

    // run 3: pseudo-random decisions with start pulses mid-run
    mode = 1;
    step(1'b1, 1'b1);
    for (int k = 0; k < 60; k++) step((k % 7) == 3, 1'b0);
    run_to_done();
    repeat (5) step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    for (int k = 0; k < 20; k++) step((k % 5) == 2, 1'b0);
    run_to_done();
    repeat (3) step(1'b0, 1'b0);

    summary();
    $finish;
  end
endmodule